// File: doc/BRIEF.md
# Branch and Loop Condition Evaluator

This unit decides, for one instruction per cycle, whether a conditional jump, a counted loop or a count-zero jump is taken. It receives the instruction kind, a 4-bit condition code, the five arithmetic flags (carry, zero, sign, overflow, parity) and the current count register value. For conditional jumps it evaluates the code against the flags, using the sign and overflow combination for signed orderings and carry with zero for unsigned orderings. For loops it produces the decremented count, a write enable for it, and a taken decision that combines the new count with the zero flag where the variant asks for it.

Target computation, fetch and flag generation sit elsewhere; flags are only read here. A parameter selects a registered output stage that adds one cycle of latency for timing closure, or a purely combinational path.

Top module: `brc_eval`

## Requirements
- R1: Kind 1 (plain loop) writes back count_i minus one modulo 2^CNT_W with count_we_o high, and is taken exactly when that new count is nonzero; a count of 0 wraps to all ones and is taken.
- R2: Kind 2 (loop while zero set) and kind 3 (loop while zero clear) decrement and write back like R1 in every case, and are taken only when the new count is nonzero and the zero flag is 1 (kind 2) or 0 (kind 3).
- R3: Kind 4 (count-zero jump) is taken exactly when count_i is 0, keeps count_we_o low and passes count_i unchanged to count_o.
- R4: Kind 0 (conditional jump) takes a 4-bit code whose bits 3:1 select a test and whose bit 0, when 1, inverts it: 0 overflow, 2 carry, 4 zero, 6 carry or zero, 8 sign, 10 parity (even), 12 sign differs from overflow, 14 zero or sign differs from overflow; the odd codes are their complements.
- R5: Signed orderings: code 12 (less) is taken when sign differs from overflow, 14 (less-or-equal) also when zero is set; 13 (greater-or-equal) and 15 (greater) are their complements.
- R6: Unsigned orderings: code 2 (below) is taken when carry is set, 6 (below-or-equal) when carry or zero is set; 3 (above-or-equal) and 7 (above) are their complements.
- R7: Single-flag codes: 0/1 overflow set/clear, 4/5 zero set/clear (equal/not equal), 8/9 sign set/clear, 10/11 parity set/clear.
- R8: A conditional jump never writes the count: count_we_o low and count_o equal to count_i.
- R9: When valid_i is low, or for the reserved kinds 5 to 7, taken_o and count_we_o are low and count_o equals count_i; valid_o follows valid_i.
- R10: With OUT_REG=1 every output reflects the inputs of the previous rising clock edge, and while rst_n is low all outputs are 0; with OUT_REG=0 outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An instruction is present |
| kind_i | input | 3 | 0 jump on code, 1 loop, 2 loop while zero, 3 loop while not zero, 4 count-zero jump |
| cond_i | input | 4 | Condition code for kind 0 |
| cf_i | input | 1 | Carry flag |
| zf_i | input | 1 | Zero flag |
| sf_i | input | 1 | Sign flag |
| of_i | input | 1 | Overflow flag |
| pf_i | input | 1 | Parity flag (even parity) |
| count_i | input | CNT_W | Current count register |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| count_we_o | output | 1 | Write the count register with count_o |
| count_o | output | CNT_W | New count value (unchanged count when not written) |

## Verification
The loop-while variants fold two functions into one cycle: the count decrement with its nonzero test, and the zero-flag qualifier. They meet hardest when the incoming count is 1 (new count zero, so the flag must not rescue the branch) and 0 (wrap to all ones, so the flag alone decides). The bench sweeps every count of a 4-bit configuration against all 32 flag combinations for each kind, so both corners appear with the zero flag set and clear, and it judges taken and the written-back count against values it derives arithmetically from the flags and count.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int KIND_W = 3;
    localparam int COND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        BRK_COND     = 3'd0,
        BRK_LOOP     = 3'd1,
        BRK_LOOP_ZS  = 3'd2,
        BRK_LOOP_ZC  = 3'd3,
        BRK_CNT_ZERO = 3'd4
    } kind_e;

    // Test selectors (cond[3:1]); cond[0] inverts the test.
    localparam logic [2:0] TST_OVF    = 3'd0;
    localparam logic [2:0] TST_CARRY  = 3'd1;
    localparam logic [2:0] TST_ZERO   = 3'd2;
    localparam logic [2:0] TST_ULE    = 3'd3;
    localparam logic [2:0] TST_SIGN   = 3'd4;
    localparam logic [2:0] TST_PAR    = 3'd5;
    localparam logic [2:0] TST_SLT    = 3'd6;
    localparam logic [2:0] TST_SLE    = 3'd7;

    localparam logic [COND_W-1:0] CC_SLT = 4'd12;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
        logic pf;
    } flag_t;

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  flag_t             flags_i,
    output logic              hit_o
);

    logic sgn_lt;
    logic base;

    always_comb begin
        sgn_lt = flags_i.sf ^ flags_i.of;
        unique case (cond_i[COND_W-1:1])
            TST_OVF:   base = flags_i.of;
            TST_CARRY: base = flags_i.cf;
            TST_ZERO:  base = flags_i.zf;
            TST_ULE:   base = flags_i.cf | flags_i.zf;
            TST_SIGN:  base = flags_i.sf;
            TST_PAR:   base = flags_i.pf;
            TST_SLT:   base = sgn_lt;
            TST_SLE:   base = flags_i.zf | sgn_lt;
            default:   base = 1'b0;
        endcase
        hit_o = base ^ cond_i[0];
    end

endmodule

// File: rtl/brc_count_unit.sv
module brc_count_unit #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] dec_o,
    output logic             dec_nz_o,
    output logic             zero_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        dec_o    = count_i - ONE;
        dec_nz_o = |dec_o;
        zero_o   = ~|count_i;
    end

endmodule

// File: rtl/brc_eval.sv
module brc_eval
    import brc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [2:0]       kind_i,
    input  logic [3:0]       cond_i,
    input  logic             cf_i,
    input  logic             zf_i,
    input  logic             sf_i,
    input  logic             of_i,
    input  logic             pf_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             valid_o,
    output logic             taken_o,
    output logic             count_we_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic             valid;
        logic             taken;
        logic             count_we;
        logic [CNT_W-1:0] count;
    } res_t;

    flag_t            flags;
    logic             cond_hit;
    logic [CNT_W-1:0] cnt_dec;
    logic             dec_nz;
    logic             cnt_zero;
    res_t             res_d;
    res_t             res_q;

    assign flags = '{cf: cf_i, zf: zf_i, sf: sf_i, of: of_i, pf: pf_i};

    brc_cond_eval u_cond (
        .cond_i  (cond_i),
        .flags_i (flags),
        .hit_o   (cond_hit)
    );

    brc_count_unit #(.CNT_W(CNT_W)) u_count (
        .count_i  (count_i),
        .dec_o    (cnt_dec),
        .dec_nz_o (dec_nz),
        .zero_o   (cnt_zero)
    );

    always_comb begin
        res_d          = '0;
        res_d.valid    = valid_i;
        res_d.count    = count_i;
        if (valid_i) begin
            case (kind_i)
                BRK_COND: begin
                    res_d.taken = cond_hit;
                end
                BRK_LOOP: begin
                    res_d.count_we = 1'b1;
                    res_d.count    = cnt_dec;
                    res_d.taken    = dec_nz;
                end
                BRK_LOOP_ZS: begin
                    res_d.count_we = 1'b1;
                    res_d.count    = cnt_dec;
                    res_d.taken    = dec_nz & zf_i;
                end
                BRK_LOOP_ZC: begin
                    res_d.count_we = 1'b1;
                    res_d.count    = cnt_dec;
                    res_d.taken    = dec_nz & ~zf_i;
                end
                BRK_CNT_ZERO: begin
                    res_d.taken = cnt_zero;
                end
                default: begin
                    res_d.taken = 1'b0;
                end
            endcase
        end
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_d;
            end

            assert_pipe_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
                valid_i |=> valid_o)
                else $error("valid did not appear one cycle later");
        end else begin : g_comb
            always_comb res_q = res_d;
        end
    endgenerate

    assign valid_o    = res_q.valid;
    assign taken_o    = res_q.taken;
    assign count_we_o = res_q.count_we;
    assign count_o    = res_q.count;

    assert_loop_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == BRK_LOOP && count_i == CNT_W'(1)) |-> !res_d.taken)
        else $error("loop taken with count reaching zero");

    assert_loopz_needs_zf_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == BRK_LOOP_ZS && !zf_i) |-> !res_d.taken)
        else $error("loop-while-zero taken with zero flag clear");

    assert_cntz_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == BRK_CNT_ZERO) |-> (!res_d.count_we && res_d.count == count_i))
        else $error("count-zero jump altered the count");

    assert_signed_lt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == BRK_COND && cond_i == CC_SLT) |-> (res_d.taken == (sf_i ^ of_i)))
        else $error("signed less decided wrongly");

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> (!res_d.taken && !res_d.count_we))
        else $error("activity without valid");

endmodule

// File: tb/brc_eval_tb.sv
`timescale 1ns/1ps
module brc_eval_tb;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          valid_i;
    logic [2:0]    kind_i;
    logic [3:0]    cond_i;
    logic          cf_i, zf_i, sf_i, of_i, pf_i;
    logic [CW-1:0] count_i;
    logic          valid_o, taken_o, count_we_o;
    logic [CW-1:0] count_o;

    int            n_tests = 0;
    int            n_fail  = 0;
    bit            have    = 1'b0;
    logic          e_valid, e_taken, e_we;
    logic [CW-1:0] e_cnt;
    string         e_tag;

    always #2.5 clk = ~clk;

    brc_eval #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i),
        .cond_i(cond_i), .cf_i(cf_i), .zf_i(zf_i), .sf_i(sf_i), .of_i(of_i),
        .pf_i(pf_i), .count_i(count_i), .valid_o(valid_o), .taken_o(taken_o),
        .count_we_o(count_we_o), .count_o(count_o)
    );

    task automatic check_out();
        n_tests++;
        if (valid_o !== e_valid || taken_o !== e_taken ||
            count_we_o !== e_we || count_o !== e_cnt) begin
            n_fail++;
            $display("FAIL %s: v/taken/we/cnt=%0b/%0b/%0b/%0h expected %0b/%0b/%0b/%0h",
                     e_tag, valid_o, taken_o, count_we_o, count_o,
                     e_valid, e_taken, e_we, e_cnt);
        end
    endtask

    function automatic string tag_of(bit v, int k, int c);
        if (!v) return "R9 idle";
        case (k)
            0: case (c >> 1)
                   1, 3:    return "R6 R4 R8";
                   6, 7:    return "R5 R4 R8";
                   default: return "R7 R4 R8";
               endcase
            1:       return "R1";
            2, 3:    return "R2";
            4:       return "R3";
            default: return "R9 reserved";
        endcase
    endfunction

    // Drive one instruction at a falling edge; the outputs seen at the next
    // falling edge belong to the previous instruction (one register stage).
    task automatic step(input bit v, input int k, input int c, input int f, input int n);
        logic [CW-1:0] cnt;
        logic [CW-1:0] nxt;
        logic          cf, zf, sf, of_, pf, lt, base;
        @(negedge clk);
        if (have) check_out();
        cnt = CW'(n);
        cf = f[0]; zf = f[1]; sf = f[2]; of_ = f[3]; pf = f[4];
        valid_i = v; kind_i = 3'(k); cond_i = 4'(c);
        cf_i = cf; zf_i = zf; sf_i = sf; of_i = of_; pf_i = pf;
        count_i = cnt;
        nxt = (cnt == '0) ? {CW{1'b1}} : CW'(n - 1);
        lt  = (sf != of_);
        e_valid = v; e_taken = 1'b0; e_we = 1'b0; e_cnt = cnt;
        e_tag = tag_of(v, k, c);
        if (v) begin
            case (k)
                0: begin
                    case (c / 2)
                        0: base = of_;
                        1: base = cf;
                        2: base = zf;
                        3: base = cf || zf;
                        4: base = sf;
                        5: base = pf;
                        6: base = lt;
                        default: base = zf || lt;
                    endcase
                    e_taken = (c % 2 == 1) ? !base : base;
                end
                1: begin e_we = 1'b1; e_cnt = nxt; e_taken = (nxt != 0); end
                2: begin e_we = 1'b1; e_cnt = nxt; e_taken = (nxt != 0) && zf; end
                3: begin e_we = 1'b1; e_cnt = nxt; e_taken = (nxt != 0) && !zf; end
                4: e_taken = (cnt == 0);
                default: ;
            endcase
        end
        have = 1'b1;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        valid_i = 1'b1; kind_i = 3'd1; cond_i = 4'd0;
        cf_i = 1'b1; zf_i = 1'b1; sf_i = 1'b0; of_i = 1'b0; pf_i = 1'b0;
        count_i = 4'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: held in reset, all outputs zero despite active inputs
        e_valid = 1'b0; e_taken = 1'b0; e_we = 1'b0; e_cnt = '0;
        e_tag = "R10 reset";
        check_out();
        valid_i = 1'b0;
        rst_n = 1'b1;

        // conditional jumps: every code, flag combination and count
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 32; f++)
                for (int n = 0; n < 16; n++)
                    step(1'b1, 0, c, f, n);

        // loops, count-zero jump and reserved kinds
        for (int k = 1; k < 8; k++)
            for (int f = 0; f < 32; f++)
                for (int n = 0; n < 16; n++)
                    step(1'b1, k, f % 16, f, n);

        // valid low for every kind
        for (int k = 0; k < 8; k++)
            for (int f = 0; f < 32; f++)
                step(1'b0, k, f % 16, f, (f * 3) % 16);

        @(negedge clk);
        check_out();
        summary();
        $finish;
    end

endmodule